// File: doc/BRIEF.md
# Three-Slice LED Chain Frame Encoder

This block turns one 32-bit message word into a serial frame on a single wire that feeds a chain of addressable RGB LED bulbs. The wire idles low. A frame opens with a one-slice high pulse and then carries 26 data bits. Each bit occupies three equal time slices: a low slice, a slice whose level depends on the data, and a high slice. A low gap of several slices then separates the frame from the next one.

A producer offers words with a valid/ready handshake. The encoder accepts a word while it is idle. It also accepts one word during the inter-frame gap; that word is held and its frame begins in the cycle after the gap ends, so back-to-back frames lose no time. A runtime slice length, counted in clock cycles, sets all of the timing. At an 80 MHz clock the default is 800 cycles (10 us per slice, 30 us per bit), and values from roughly 5 us to 15 us are expected. A busy flag marks the whole frame, from the start pulse to the end of the gap.

Top module: `led3_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `line_out` is 0, `busy` is 0 and `msg_ready` is 1.
- R2: When a word is accepted (`msg_valid` and `msg_ready` high at a rising clock edge) while idle, `busy` and `line_out` go high in the next cycle. `line_out` stays high for exactly one slice, which is the start pulse.
- R3: Each data bit lasts three slices. The first slice is always low and the third is always high.
- R4: The 26 transmitted bits are word bits 29 down to 4, most significant first. In the middle slice the line is high for a 0 bit and low for a 1 bit. Word bits 31:30 and 3:0 have no effect on the line.
- R5: After the high slice of the last bit, the line is low for `GAP_SLICES` slices (default 4, never fewer than 3). `busy` stays high through the gap and falls in the cycle after it ends, unless another frame follows.
- R6: One slice is `slice_len` clock cycles. A value of 0 counts as 1. The value is sampled in the cycle in which a frame begins (the cycle before the start pulse appears), and later changes have no effect on that frame.
- R7: `msg_ready` is 1 while idle, and 1 during the gap while no word is held. It is 0 in every other cycle.
- R8: A word accepted during the gap, including in its final cycle, starts its frame in the cycle right after the gap ends. The start pulse follows the last gap cycle directly, and `busy` does not drop in between.
- R9: `msg_valid` while `msg_ready` is 0 is ignored. No frame results from it, and the frame in progress is not altered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slice_len | input | SLICE_W | Slice length in clock cycles (0 counts as 1) |
| msg_word | input | 32 | Message word; bits 29:4 are transmitted |
| msg_valid | input | 1 | Producer offers `msg_word` |
| msg_ready | output | 1 | Encoder can take a word this cycle |
| line_out | output | 1 | Serial line to the LED chain |
| busy | output | 1 | High from the start pulse to the end of the gap |

## Verification
The hardest situation to reach from the ports is a word accepted in the very last cycle of the gap. In that cycle the gap-end decision and the acceptance coincide, and the new frame has to start from the input word directly rather than from the hold register. The stimulus reaches that cycle by counting 83 slices from the previous acceptance at a known slice length, and it repeats the case one cycle earlier so that the hold register is used for a single cycle. A behavioural model built from queued slot levels then compares the line, `busy` and `msg_ready` on every clock, across slice lengths of 0, 1, small values and 800, and across a slice-length change in the middle of a frame.

// File: rtl/led3_pkg.sv
// Shared constants and types for the three-slice LED frame encoder.
// Assumes a 32-bit message word whose transmitted field is bits 29..4.
package led3_pkg;
    localparam int MSG_W      = 32;
    localparam int FRAME_MSB  = 29;
    localparam int FRAME_LSB  = 4;
    localparam int FRAME_BITS = FRAME_MSB - FRAME_LSB + 1;

    // Frame sequencer states; the line level is decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_LOW   = 3'd2,
        ST_MID   = 3'd3,
        ST_HIGH  = 3'd4,
        ST_GAP   = 3'd5
    } led3_state_e;
endpackage

// File: rtl/led3_slice_timer.sv
// Slice timer: counts clock cycles inside the current slice and flags its
// last cycle. The slice length is captured when a frame begins (load) and
// held for the whole frame; a zero request is treated as one cycle.
// Assumes run is low only while the encoder is idle.
module led3_slice_timer #(
    parameter int SLICE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [SLICE_W-1:0] len_in,
    input  logic               run,
    output logic               slice_end,
    output logic [SLICE_W-1:0] cnt_q,
    output logic [SLICE_W-1:0] len_q
);
    logic [SLICE_W-1:0] len_eff;

    // Clamp the requested length to at least one cycle.
    always_comb begin
        len_eff = (len_in == '0) ? SLICE_W'(1) : len_in;
    end

    // Last cycle of the current slice.
    always_comb begin
        slice_end = run && (cnt_q == (len_q - SLICE_W'(1)));
    end

    // Capture the length at frame start and advance the in-slice counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= SLICE_W'(1);
            cnt_q <= '0;
        end else begin
            if (load) begin
                len_q <= len_eff;
            end
            if (load || !run || slice_end) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + SLICE_W'(1);
            end
        end
    end
endmodule

// File: rtl/led3_bit_shifter.sv
// Data path: holds one word accepted during the gap, loads the 26-bit
// transmit field at frame start, and shifts it most significant bit first.
// Assumes frame_go and accept come from the sequencer and top, and that a
// hold is only requested while a frame is in progress.
module led3_bit_shifter
    import led3_pkg::*;
#(
    parameter int IDX_W = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  accept,
    input  logic                  frame_go,
    input  logic                  adv_bit,
    input  logic [FRAME_BITS-1:0] field_in,
    output logic                  pend_valid,
    output logic                  data_bit,
    output logic                  last_bit,
    output logic [IDX_W-1:0]      bit_idx
);
    logic [FRAME_BITS-1:0] pend_field;
    logic [FRAME_BITS-1:0] shreg;
    logic [FRAME_BITS-1:0] load_field;

    // The word for a new frame comes from the hold register if it is full.
    always_comb begin
        load_field = pend_valid ? pend_field : field_in;
    end

    // Current data bit and end-of-frame detection.
    always_comb begin
        data_bit = shreg[FRAME_BITS-1];
        last_bit = (bit_idx == IDX_W'(FRAME_BITS - 1));
    end

    // One-deep hold register for a word accepted during the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_field <= '0;
        end else if (frame_go) begin
            pend_valid <= 1'b0;
        end else if (accept) begin
            pend_valid <= 1'b1;
            pend_field <= field_in;
        end
    end

    // Shift register and bit index for the frame in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
        end else if (frame_go) begin
            shreg   <= load_field;
            bit_idx <= '0;
        end else if (adv_bit) begin
            shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
            bit_idx <= bit_idx + IDX_W'(1);
        end
    end
endmodule

// File: rtl/led3_frame_fsm.sv
// Frame sequencer: walks start pulse, three slices per bit and the gap,
// counting gap slices. It decides when a new frame begins (frame_go) and
// when the data path advances to the next bit.
// Assumes slice_end comes from the slice timer for the current state.
module led3_frame_fsm
    import led3_pkg::*;
#(
    parameter int GAP_SLICES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slice_end,
    input  logic        last_bit,
    input  logic        accept,
    input  logic        pend_valid,
    output led3_state_e state,
    output logic        frame_go,
    output logic        adv_bit
);
    localparam int GAP_N = (GAP_SLICES < 3) ? 3 : GAP_SLICES;
    localparam int GAP_W = $clog2(GAP_N + 1);

    led3_state_e       state_nx;
    logic [GAP_W-1:0]  gap_cnt;
    logic              gap_done;

    // Final cycle of the final gap slice.
    always_comb begin
        gap_done = (state == ST_GAP) && slice_end && (gap_cnt == GAP_W'(GAP_N - 1));
    end

    // A frame begins from idle on acceptance, or at gap end with a word in hand.
    always_comb begin
        frame_go = ((state == ST_IDLE) && accept) ||
                   (gap_done && (pend_valid || accept));
        adv_bit  = (state == ST_HIGH) && slice_end && !last_bit;
    end

    // Next-state selection.
    always_comb begin
        state_nx = state;
        case (state)
            ST_IDLE:  if (frame_go)  state_nx = ST_START;
            ST_START: if (slice_end) state_nx = ST_LOW;
            ST_LOW:   if (slice_end) state_nx = ST_MID;
            ST_MID:   if (slice_end) state_nx = ST_HIGH;
            ST_HIGH:  if (slice_end) state_nx = last_bit ? ST_GAP : ST_LOW;
            ST_GAP:   if (gap_done)  state_nx = frame_go ? ST_START : ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Gap slice counter, cleared outside the gap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (state != ST_GAP) begin
            gap_cnt <= '0;
        end else if (slice_end) begin
            gap_cnt <= gap_cnt + GAP_W'(1);
        end
    end
endmodule

// File: rtl/led3_frame_tx.sv
// Top of the three-slice LED frame encoder: handshake, line decode and
// wiring of timer, sequencer and data path.
// Assumes slice_len is meaningful when a frame begins; bits 31:30 and 3:0
// of the message word are not transmitted.
module led3_frame_tx
    import led3_pkg::*;
#(
    parameter int SLICE_W    = 16,
    parameter int GAP_SLICES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SLICE_W-1:0] slice_len,
    input  logic [MSG_W-1:0]   msg_word,
    input  logic               msg_valid,
    output logic               msg_ready,
    output logic               line_out,
    output logic               busy
);
    localparam int IDX_W = $clog2(FRAME_BITS);

    led3_state_e        state;
    logic               accept;
    logic               frame_go;
    logic               adv_bit;
    logic               slice_end;
    logic               pend_valid;
    logic               data_bit;
    logic               last_bit;
    logic [IDX_W-1:0]   bit_idx;
    logic [SLICE_W-1:0] slice_cnt;
    logic [SLICE_W-1:0] slice_len_q;
    logic               unused_word_bits;

    // Bits outside the transmitted field are deliberately dropped.
    assign unused_word_bits = ^{msg_word[MSG_W-1:FRAME_MSB+1], msg_word[FRAME_LSB-1:0]};

    // Handshake: open while idle, or during the gap with the hold empty.
    always_comb begin
        msg_ready = (state == ST_IDLE) || ((state == ST_GAP) && !pend_valid);
        accept    = msg_valid && msg_ready;
        busy      = (state != ST_IDLE);
    end

    // Line level decoded from the registered state and current data bit.
    always_comb begin
        case (state)
            ST_START: line_out = 1'b1;
            ST_MID:   line_out = !data_bit;
            ST_HIGH:  line_out = 1'b1;
            default:  line_out = 1'b0;
        endcase
    end

    led3_slice_timer #(.SLICE_W(SLICE_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_go),
        .len_in    (slice_len),
        .run       (busy),
        .slice_end (slice_end),
        .cnt_q     (slice_cnt),
        .len_q     (slice_len_q)
    );

    led3_frame_fsm #(.GAP_SLICES(GAP_SLICES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .slice_end  (slice_end),
        .last_bit   (last_bit),
        .accept     (accept),
        .pend_valid (pend_valid),
        .state      (state),
        .frame_go   (frame_go),
        .adv_bit    (adv_bit)
    );

    led3_bit_shifter #(.IDX_W(IDX_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .frame_go   (frame_go),
        .adv_bit    (adv_bit),
        .field_in   (msg_word[FRAME_MSB:FRAME_LSB]),
        .pend_valid (pend_valid),
        .data_bit   (data_bit),
        .last_bit   (last_bit),
        .bit_idx    (bit_idx)
    );
endmodule

// File: rtl/led3_frame_tx_chk.sv
// Property checker for the frame encoder, bound to the top module.
// Observes ports and a few internal registers of separate submodules.
module led3_frame_tx_chk #(
    parameter int SLICE_W = 16,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               line_out,
    input logic               busy,
    input logic               msg_ready,
    input logic               pend_valid,
    input logic [IDX_W-1:0]   bit_idx,
    input logic [SLICE_W-1:0] slice_cnt,
    input logic [SLICE_W-1:0] slice_len_q
);
    assert_idle_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!line_out && msg_ready));

    assert_start_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> line_out);

    assert_bit_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_idx <= IDX_W'(led3_pkg::FRAME_BITS - 1));

    assert_gap_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && msg_ready) |-> !line_out);

    assert_end_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !$past(line_out));

    assert_slice_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((slice_len_q != '0) && (slice_cnt < slice_len_q)));

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> !msg_ready);

    assert_hold_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> busy);
endmodule

bind led3_frame_tx led3_frame_tx_chk #(.SLICE_W(SLICE_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_out    (line_out),
    .busy        (busy),
    .msg_ready   (msg_ready),
    .pend_valid  (pend_valid),
    .bit_idx     (bit_idx),
    .slice_cnt   (slice_cnt),
    .slice_len_q (slice_len_q)
);

// File: tb/sim_led3_frame_tx.sv
// Bench: a queue of expected per-cycle line levels is built from each
// accepted word and compared with the encoder on every clock.
module sim_led3_frame_tx;
    localparam int CLK_PERIOD = 10;
    localparam int SW         = 16;
    localparam int GAPS       = 4;
    localparam int WATCHDOG   = 190000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] slice_len = SW'(3);
    logic [31:0]   msg_word = '0;
    logic          msg_valid = 1'b0;
    logic          msg_ready;
    logic          line_out;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    typedef struct {
        bit    lvl;
        bit    gap;
        string tag;
    } slot_t;

    slot_t       q[$];
    bit          pend = 1'b0;
    logic [31:0] pend_w;
    bit          idle_now;
    bit          exp_line, exp_busy, exp_ready;
    string       cur_tag;
    slot_t       s;

    always #(CLK_PERIOD/2) clk = ~clk;

    led3_frame_tx #(.SLICE_W(SW), .GAP_SLICES(GAPS)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slice_len (slice_len),
        .msg_word  (msg_word),
        .msg_valid (msg_valid),
        .msg_ready (msg_ready),
        .line_out  (line_out),
        .busy      (busy)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: got %0h expected %0h", req, $time, act, exp);
        end
    endtask

    // Expected frame: start, 26 bits (low / inverted data / high), gap.
    task automatic push_frame(input logic [31:0] w);
        int len;
        len = (slice_len == '0) ? 1 : int'(slice_len);
        for (int k = 0; k < len; k++) q.push_back('{1'b1, 1'b0, "R2"});
        for (int b = 29; b >= 4; b--) begin
            for (int k = 0; k < len; k++) q.push_back('{1'b0, 1'b0, "R3"});
            for (int k = 0; k < len; k++) q.push_back('{~w[b], 1'b0, "R4"});
            for (int k = 0; k < len; k++) q.push_back('{1'b1, 1'b0, "R3"});
        end
        for (int k = 0; k < GAPS * len; k++) q.push_back('{1'b0, 1'b1, "R5"});
    endtask

    // Reference model, compared every cycle away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            q.delete();
            pend = 1'b0;
        end else if (!done) begin
            idle_now = (q.size() == 0);
            if (idle_now) begin
                exp_line = 1'b0; exp_busy = 1'b0; exp_ready = 1'b1; cur_tag = "R1";
            end else begin
                s = q.pop_front();
                exp_line = s.lvl; exp_busy = 1'b1; exp_ready = s.gap && !pend; cur_tag = s.tag;
            end
            chk(line_out == exp_line, cur_tag, 32'(line_out), 32'(exp_line));
            chk(busy == exp_busy, (exp_busy ? "R5" : "R1"), 32'(busy), 32'(exp_busy));
            chk(msg_ready == exp_ready, "R7", 32'(msg_ready), 32'(exp_ready));
            if (msg_valid && exp_ready) begin
                if (idle_now) push_frame(msg_word);
                else begin pend = 1'b1; pend_w = msg_word; end
            end
            // R8: a held word starts right after the gap's last cycle
            if (!idle_now && q.size() == 0 && pend) begin
                push_frame(pend_w);
                pend = 1'b0;
            end
        end
    end

    task automatic send(input logic [31:0] w);
        bit r;
        msg_valid = 1'b1;
        msg_word  = w;
        do begin
            @(negedge clk);
            r = msg_ready;
            @(posedge clk); #1;
        end while (!r);
        msg_valid = 1'b0;
        msg_word  = 32'hDEAD_BEEF;
    endtask

    task automatic wait_idle();
        do @(posedge clk); while (q.size() != 0 || pend || busy);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(line_out == 1'b0, "R1", 32'(line_out), 0);
        chk(busy == 1'b0, "R1", 32'(busy), 0);
        chk(msg_ready == 1'b1, "R1", 32'(msg_ready), 1);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(posedge clk); #1;

        // R2 R3 R4: varied data patterns at slice length 3
        slice_len = SW'(3);
        send(32'h2A5C_3A50); wait_idle();
        send(32'h3FFF_FFF0); wait_idle();
        send(32'h0000_0000); wait_idle();
        send(32'h1555_5550); wait_idle();
        // R4: bits 31:30 and 3:0 set; model only uses bits 29:4
        send(32'hC123_456F); wait_idle();

        // R6: shortest slices, zero treated as one
        slice_len = SW'(1); send(32'h0AB1_2340); wait_idle();
        slice_len = SW'(0); send(32'h35A5_A5A0); wait_idle();

        // R6: length change in mid-frame does not affect that frame
        slice_len = SW'(4);
        send(32'h1F0F_0F00);
        repeat (40) @(posedge clk); #1;
        slice_len = SW'(9);
        wait_idle();
        send(32'h2222_2220); wait_idle();

        // R8: back-to-back words, held during the gap
        slice_len = SW'(2);
        send(32'h0123_4560);
        send(32'h3EDC_BA90);
        send(32'h1111_1110);
        wait_idle();

        // R8: acceptance in the final gap cycle (frame is 83 slices)
        send(32'h2468_ACE0);
        repeat (83 * 2 - 1) @(posedge clk); #1;
        send(32'h1357_9BD0);
        // R8: acceptance one cycle before the gap ends
        repeat (83 * 2 - 2) @(posedge clk); #1;
        send(32'h0F0F_F0F0);
        wait_idle();

        // R9: valid while not ready must be ignored
        slice_len = SW'(3);
        send(32'h3000_0010);
        msg_valid = 1'b1; msg_word = 32'h0FFF_FFF0;
        repeat (30) @(posedge clk); #1;
        msg_valid = 1'b0;
        wait_idle();
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R9", 32'(busy), 0);
        @(posedge clk); #1;

        // R6: default slice length of 800 cycles
        slice_len = SW'(800);
        send(32'h2B3C_4D50); wait_idle();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule